// File: doc/BRIEF.md
# ADC conversion sequencer

This block is the digital side of a 10-bit successive-approximation converter. Software reaches it through a byte-wide register bus with a 3-bit address. It chooses an input channel and a conversion clock rate. It starts a conversion by setting a busy bit and polls that bit until hardware clears it. It then reads the result in one of two byte layouts. A sticky completion flag marks each finished conversion.

The conversion clock is taken from the system clock through a prescaler. It can instead follow an external slow tick (`rc_tick`) that stands in for a dedicated RC oscillator. Each conversion takes one conversion-clock period for setup, then one period per result bit, starting at the MSB. During each bit period the block drives a trial code to the analog side on `dac_trial`. It keeps the trial bit when `cmp_ge` reports the input at or above that level. Channel and reference selections go straight out to the analog hardware.

Register map: address 0 is control A, address 1 is control B, address 2 is the result high byte, address 3 is the result low byte, and address 4 is status. Reads are combinational from `bus_addr`. Writes take effect at the clock edge where `bus_wr` is high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, control A, control B and status read 0x00, and `chan_sel`, `ref_neg` and `ref_pos` are 0.
- R2: Control A holds the enable in bit 0, the busy/start bit in bit 1 and the channel in bits 6:2, with bit 7 reading 0. A write with bits 0 and 1 both set starts a conversion, and bit 1 reads 1 while the conversion runs. A write that sets bit 1 with bit 0 clear starts nothing.
- R3: The busy bit clears exactly 11 conversion-clock periods after the start write. Reading it N system cycles after the start edge shows 1 for N < 11·P and 0 for N = 11·P, where P is the conversion-clock period.
- R4: Clock select codes 000, 100, 001, 101, 010 and 110 give P = 2, 4, 8, 16, 32 and 64 system clocks.
- R5: Clock select codes 011 and 111 both time the conversion by `rc_tick`. The busy bit clears at the edge that samples the 11th high `rc_tick` after the start.
- R6: The result equals the largest 10-bit code whose trial levels `cmp_ge` accepted, bit by bit from MSB to LSB. With `cmp_ge = (vin >= dac_trial)` the result equals vin.
- R7: When format bit 7 of control B is 1, the result high byte is {000000, res[9:8]} and the result low byte is res[7:0].
- R8: When format bit 7 of control B is 0, the result high byte is res[9:2] and the result low byte is {res[1:0], 000000}.
- R9: The completion flag (status bit 0) is set at the same edge where the busy bit clears and the result loads. It stays set until software writes status bit 0 as 0. Writing 1 has no effect.
- R10: Writing control A with bit 0 clear during a conversion clears the busy bit at once. It sets no flag and leaves both result bytes unchanged.
- R11: Writing control A with bit 0 set and bit 1 clear during a conversion stops it. It sets no flag and leaves both result bytes unchanged.
- R12: Control B holds format in bit 7, clock select in bits 6:4, the negative-reference select in bit 2 and the positive-reference select in bits 1:0. Bit 3 reads 0. The reference fields drive `ref_neg` and `ref_pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| rc_tick | input | 1 | Slow clock enable from the RC source |
| cmp_ge | input | 1 | Comparator: input at or above trial level |
| dac_trial | output | 10 | Trial code presented to the comparator |
| chan_sel | output | 5 | Analog channel select |
| ref_neg | output | 1 | Negative reference select |
| ref_pos | output | 2 | Positive reference select |
| done_irq | output | 1 | Sticky completion flag |

## Verification
The main stimulus is a comparator modelled from a bench-held analog code. Random codes, formats and prescaler settings are mixed with the extreme codes 0x000 and 0x3FF and one code with a single set bit at each end, 0x201. The extremes catch a stuck or misordered trial bit. 0x201 separates the two justification layouts and shows that the zero fill lands on the right byte. Each random run also measures the busy time in system cycles, so a wrong divide for any select code shows up apart from a result error. The RC runs hand out ticks one at a time, so an off-by-one in the step count is visible. The two abort paths are run after a known result and must leave that result and the flag untouched.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W = 10,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             rc_tick,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] dac_trial,
  output logic [4:0]       chan_sel,
  output logic             ref_neg,
  output logic [1:0]       ref_pos,
  output logic             done_irq
);
  localparam int STEP_W = $clog2(RES_W + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RES_W);

  logic             en_q, go_q, fmt_q, nref_q, irq_q;
  logic [4:0]       ch_q;
  logic [2:0]       csel_q;
  logic [1:0]       pref_q;
  logic [7:0]       res_hi, res_lo;
  logic [CNT_W-1:0] cnt_q, cnt_last;
  logic [STEP_W-1:0] step_q;
  logic [RES_W-1:0] sar_q, mask, final_code;
  logic             wr_a, wr_b, wr_st, tick, finish;

  assign wr_a  = bus_wr && bus_addr == 3'd0;
  assign wr_b  = bus_wr && bus_addr == 3'd1;
  assign wr_st = bus_wr && bus_addr == 3'd4;

  always_comb begin
    case (csel_q)
      3'b000:  cnt_last = CNT_W'(1);
      3'b100:  cnt_last = CNT_W'(3);
      3'b001:  cnt_last = CNT_W'(7);
      3'b101:  cnt_last = CNT_W'(15);
      3'b010:  cnt_last = CNT_W'(31);
      default: cnt_last = CNT_W'(63);
    endcase
  end

  assign tick   = go_q && !wr_a && ((csel_q[1:0] == 2'b11) ? rc_tick : (cnt_q == cnt_last));
  assign mask   = (step_q == '0) ? '0 : (RES_W'(1) << (LAST_STEP - step_q));
  assign dac_trial  = sar_q | mask;
  assign final_code = cmp_ge ? (sar_q | mask) : sar_q;
  assign finish = tick && step_q == LAST_STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; go_q <= 1'b0; ch_q <= '0;
      fmt_q <= 1'b0; csel_q <= '0; nref_q <= 1'b0; pref_q <= '0;
      irq_q <= 1'b0; cnt_q <= '0; step_q <= '0; sar_q <= '0;
    end else begin
      if (wr_b) begin
        fmt_q  <= bus_wdata[7];
        csel_q <= bus_wdata[6:4];
        nref_q <= bus_wdata[2];
        pref_q <= bus_wdata[1:0];
      end
      if (wr_st && !bus_wdata[0]) irq_q <= 1'b0;
      if (wr_a) begin
        ch_q <= bus_wdata[6:2];
        en_q <= bus_wdata[0];
        if (!bus_wdata[0] || !bus_wdata[1]) begin
          go_q <= 1'b0;
          step_q <= '0;
        end else if (!go_q) begin
          go_q <= 1'b1;
          step_q <= '0;
          sar_q <= '0;
          cnt_q <= '0;
        end
      end else if (go_q) begin
        cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (tick) begin
          if (step_q == '0) begin
            sar_q <= '0;
            step_q <= step_q + 1'b1;
          end else begin
            sar_q <= final_code;
            if (finish) begin
              go_q <= 1'b0;
              step_q <= '0;
              irq_q <= 1'b1;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (finish) begin
      if (fmt_q) begin
        res_hi <= {6'b0, final_code[9:8]};
        res_lo <= final_code[7:0];
      end else begin
        res_hi <= final_code[9:2];
        res_lo <= {final_code[1:0], 6'b0};
      end
    end else if (bus_wr && bus_addr == 3'd2) begin
      res_hi <= bus_wdata;
    end else if (bus_wr && bus_addr == 3'd3) begin
      res_lo <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {1'b0, ch_q, go_q, en_q};
      3'd1:    bus_rdata = {fmt_q, csel_q, 1'b0, nref_q, pref_q};
      3'd2:    bus_rdata = res_hi;
      3'd3:    bus_rdata = res_lo;
      3'd4:    bus_rdata = {7'b0, irq_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign chan_sel = ch_q;
  assign ref_neg  = nref_q;
  assign ref_pos  = pref_q;
  assign done_irq = irq_q;

  assert_busy_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> en_q);
  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP);
  assert_flag_on_completion_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $fell(go_q));
  assert_right_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_q) && $past(fmt_q)) |-> res_hi[7:2] == 6'b0);
  assert_left_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_q) && !$past(fmt_q)) |-> res_lo[5:0] == 6'b0);
  assert_abort_keeps_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(go_q) && !$rose(irq_q)) |-> ($stable(res_hi) && $stable(res_lo)));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rc_tick = 1'b0;
  logic       cmp_ge;
  logic [9:0] dac_trial;
  logic [4:0] chan_sel;
  logic       ref_neg;
  logic [1:0] ref_pos;
  logic       done_irq;
  logic [9:0] vin = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmp_ge = (vin >= dac_trial);

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rc_tick(rc_tick),
    .cmp_ge(cmp_ge), .dac_trial(dac_trial), .chan_sel(chan_sel),
    .ref_neg(ref_neg), .ref_pos(ref_pos), .done_irq(done_irq)
  );

  function automatic int div_of(input logic [2:0] s);
    case (s)
      3'b000: return 2;  3'b100: return 4;
      3'b001: return 8;  3'b101: return 16;
      3'b010: return 32; default: return 64;
    endcase
  endfunction

  function automatic logic [7:0] exp_hi(input logic [9:0] v, input logic f);
    return f ? {6'b0, v[9:8]} : v[9:2];
  endfunction

  function automatic logic [7:0] exp_lo(input logic [9:0] v, input logic f);
    return f ? v[7:0] : {v[1:0], 6'b0};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic convert(input logic [9:0] v, input logic f, input logic [2:0] s,
                         input logic [4:0] ch, input string req);
    logic [7:0] d;
    int n;
    vin = v;
    wr(3'd4, 8'h00);
    wr(3'd1, {f, s, 4'b0000});
    wr(3'd0, {1'b0, ch, 2'b11});
    n = 0;
    rd(3'd0, d);
    chk("R2 busy after start", int'(d[1]), 1);
    while (d[1]) begin
      @(negedge clk);
      n++;
      rd(3'd0, d);
    end
    chk({req, " R3 busy time"}, n, 11 * div_of(s));
    rd(3'd2, d);
    chk({req, f ? " R7 high" : " R8 high", " R6"}, int'(d), int'(exp_hi(v, f)));
    rd(3'd3, d);
    chk({req, f ? " R7 low" : " R8 low", " R6"}, int'(d), int'(exp_lo(v, f)));
    rd(3'd4, d);
    chk({req, " R9 flag"}, int'(d), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [2:0] sels [6];
    void'($urandom(32'd1357));
    sels = '{3'b000, 3'b100, 3'b001, 3'b101, 3'b010, 3'b110};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd0, d); chk("R1 control A reset", int'(d), 0);
    rd(3'd1, d); chk("R1 control B reset", int'(d), 0);
    rd(3'd4, d); chk("R1 status reset", int'(d), 0);
    chk("R1 outputs reset", int'({chan_sel, ref_neg, ref_pos}), 0);

    wr(3'd1, 8'hFF);
    rd(3'd1, d); chk("R12 control B readback", int'(d), 8'hF7);
    chk("R12 ref outputs", int'({ref_neg, ref_pos}), 3'b111);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'hBC);
    rd(3'd0, d); chk("R2 control A readback", int'(d), 8'h3C);
    chk("R2 channel output", int'(chan_sel), 15);
    wr(3'd0, 8'h3A);
    repeat (40) @(negedge clk);
    rd(3'd0, d); chk("R2 start ignored while disabled", int'(d), 8'h38);
    rd(3'd4, d); chk("R2 no flag while disabled", int'(d), 0);

    convert(10'h3FF, 1'b1, 3'b000, 5'd3, "full scale");
    repeat (20) @(negedge clk);
    rd(3'd4, d); chk("R9 flag sticky", int'(d), 1);
    wr(3'd4, 8'h01);
    rd(3'd4, d); chk("R9 write 1 no effect", int'(d), 1);
    wr(3'd4, 8'h00);
    rd(3'd4, d); chk("R9 flag cleared", int'(d), 0);
    chk("R9 port cleared", int'(done_irq), 0);
    convert(10'h000, 1'b0, 3'b100, 5'd13, "zero");
    convert(10'h201, 1'b0, 3'b001, 5'd14, "left edge");
    convert(10'h201, 1'b1, 3'b101, 5'd0, "right edge");

    for (int i = 0; i < 24; i++) begin
      convert(10'($urandom), 1'($urandom), sels[$urandom % 6], 5'($urandom % 15), "R4 random");
    end

    for (int k = 0; k < 2; k++) begin
      logic [2:0] s;
      s = k ? 3'b111 : 3'b011;
      vin = 10'h15A;
      wr(3'd4, 8'h00);
      wr(3'd1, {1'b1, s, 4'b0});
      wr(3'd0, 8'h07);
      repeat (100) @(negedge clk);
      for (int t = 0; t < 10; t++) begin
        rc_tick = 1'b1; @(negedge clk); rc_tick = 1'b0;
        repeat (3) @(negedge clk);
      end
      rd(3'd0, d); chk("R5 busy after 10 ticks", int'(d[1]), 1);
      rc_tick = 1'b1; @(negedge clk); rc_tick = 1'b0;
      rd(3'd0, d); chk("R5 done after 11 ticks", int'(d[1]), 0);
      rd(3'd3, d); chk("R5 R6 result low", int'(d), 8'h5A);
      rd(3'd2, d); chk("R5 R6 result high", int'(d), 8'h01);
    end

    convert(10'h2C4, 1'b1, 3'b000, 5'd1, "before abort");
    wr(3'd4, 8'h00);
    vin = 10'h011;
    wr(3'd1, 8'h20);
    wr(3'd0, 8'h07);
    repeat (150) @(negedge clk);
    wr(3'd0, 8'h04);
    rd(3'd0, d); chk("R10 busy cleared by disable", int'(d[1]), 0);
    repeat (800) @(negedge clk);
    rd(3'd4, d); chk("R10 no flag", int'(d), 0);
    rd(3'd2, d); chk("R10 high kept", int'(d), 8'h02);
    rd(3'd3, d); chk("R10 low kept", int'(d), 8'hC4);

    wr(3'd0, 8'h07);
    repeat (150) @(negedge clk);
    wr(3'd0, 8'h05);
    rd(3'd0, d); chk("R11 busy cleared by software", int'(d[1]), 0);
    repeat (800) @(negedge clk);
    rd(3'd4, d); chk("R11 no flag", int'(d), 0);
    rd(3'd2, d); chk("R11 high kept", int'(d), 8'h02);
    rd(3'd3, d); chk("R11 low kept", int'(d), 8'hC4);

    convert(10'h011, 1'b0, 3'b010, 5'd1, "after abort");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule